// File: doc/BRIEF.md
# Interrupt Consolidator with Software-Raised Virtual Interrupts

This block gathers the interrupt requests of a four-core system into one place. Hardware maskable sources are sampled once and then gated by a separate enable word for each core and by one enable word for the external request output. Hardware non-maskable sources are sampled and sent unmasked to every core and to the external NMI output. Each core's interrupt line is high when any of its enabled hardware sources is high, or when any of its enabled virtual interrupts is pending.

Software raises interrupts through a small register port. Each core owns eight virtual maskable interrupts. They are set and cleared by plain writes to a write-1-to-set register and a write-1-to-clear register, so no read-modify-write is needed and two writers cannot corrupt each other's bits. Each core also owns one virtual NMI. A write to the trigger register fires that NMI as a single-cycle pulse that bypasses every mask. Status words report the sampled hardware levels and the pending virtual bits.

Register map (4-bit address, 32-bit data). 0 is the virtual set register, and a read returns the pending bits. 1 is the virtual clear register, and a read also returns the pending bits. 2 is the virtual NMI trigger, and it reads as 0. 3 is the virtual enable word. 4 to 7 hold the hardware enable word of cores 0 to 3. 8 is the external enable word. 9 is the hardware maskable status (read-only). 10 is the hardware NMI status (read-only). Any other address reads as 0. In every 32-bit virtual word, bits [8c+7:8c] belong to core c.

Top module: `irq_merge_hub`

## Requirements
- R1: After reset all pending bits, enable words and NMI pulses are 0. `core_int`, `core_nmi`, `int_out` and `nmi_out` are low, and every register reads 0 while no source is active.
- R2: A write to address 0 sets each pending virtual bit whose data bit is 1 and leaves the bits written as 0 unchanged. The new state is visible right after the write clock edge. Bits [8c+7:8c] belong to core c.
- R3: A write to address 1 clears each pending virtual bit whose data bit is 1 and leaves the other bits unchanged.
- R4: `core_int[c]` is high exactly when (sampled hardware levels AND the core c enable word at address 4+c) is nonzero, or when (pending bits AND the enable word at address 3) is nonzero within core c's byte. Hardware inputs reach the output one clock edge after they are applied.
- R5: `int_out` is the OR of the sampled hardware maskable levels ANDed with the enable word at address 8. Virtual interrupts never drive `int_out`.
- R6: A write to address 2 with data bit c set drives `core_nmi[c]` high for exactly the one cycle after the write edge, whatever the masks hold. It does not drive `nmi_out`.
- R7: While any sampled hardware NMI source is high, `nmi_out` and every `core_nmi` bit are high. No mask applies to them.
- R8: Changing an enable word does not change the pending bits. A pending bit that was masked raises `core_int` once its enable bit is set.
- R9: Addresses 9 and 10 read the sampled hardware maskable and NMI levels, and writes to them are ignored. Addresses 3 to 8 read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_irq | input | NUM_HW (16) | Hardware maskable request levels |
| hw_nmi | input | NUM_NMI (4) | Hardware non-maskable request levels |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for both write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for reg_addr (combinational) |
| core_int | output | NUM_CORES (4) | Per-core maskable interrupt line |
| core_nmi | output | NUM_CORES (4) | Per-core non-maskable interrupt line |
| int_out | output | 1 | External maskable request |
| nmi_out | output | 1 | External non-maskable request |

## Verification
The assertions take for granted that the hardware inputs change only between clock edges and that at most one register write happens per cycle, so a set and a clear never meet in the same cycle. The bench drives every input on the falling edge and issues writes one at a time through a single task, which keeps within both assumptions. The virtual NMI checks assume that no second trigger write comes in the cycle after the first. The stimulus always leaves an idle cycle after a trigger, so the single-cycle pulse can be seen falling.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 32;
  localparam logic [ADDR_W-1:0] A_VSET   = 4'd0;
  localparam logic [ADDR_W-1:0] A_VCLR   = 4'd1;
  localparam logic [ADDR_W-1:0] A_VNMI   = 4'd2;
  localparam logic [ADDR_W-1:0] A_VMASK  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CEN0   = 4'd4;
  localparam logic [ADDR_W-1:0] A_EXTEN  = 4'd8;
  localparam logic [ADDR_W-1:0] A_HWSTAT = 4'd9;
  localparam logic [ADDR_W-1:0] A_NMISTAT = 4'd10;

  // Address of the hardware enable word for a given core.
  function automatic logic [ADDR_W-1:0] cen_addr(input int core);
    return ADDR_W'(int'(A_CEN0) + core);
  endfunction

  // Any bit set in both words.
  function automatic logic any_hit(input logic [DATA_W-1:0] src,
                                   input logic [DATA_W-1:0] en);
    return |(src & en);
  endfunction

  // Pending after a set/clear write.
  function automatic logic [DATA_W-1:0] apply_w1(input logic [DATA_W-1:0] cur,
                                                 input logic [DATA_W-1:0] d,
                                                 input logic              is_set);
    return is_set ? (cur | d) : (cur & ~d);
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_merge_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_HW    = 16,
  parameter int VIRT_PER_CORE = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [NUM_CORES*VIRT_PER_CORE-1:0] vmask,
  output logic [NUM_CORES*NUM_HW-1:0]   core_en,
  output logic [NUM_HW-1:0]             ext_en
);
  localparam int VW = NUM_CORES * VIRT_PER_CORE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vmask  <= '0;
      ext_en <= '0;
    end else if (wr_en) begin
      if (reg_addr == A_VMASK) vmask  <= wr_data[VW-1:0];
      if (reg_addr == A_EXTEN) ext_en <= wr_data[NUM_HW-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_cen
    always_ff @(posedge clk) begin
      if (!rst_n)
        core_en[c*NUM_HW +: NUM_HW] <= '0;
      else if (wr_en && reg_addr == cen_addr(c))
        core_en[c*NUM_HW +: NUM_HW] <= wr_data[NUM_HW-1:0];
    end
  end
endmodule

// File: rtl/irq_virt_bank.sv
module irq_virt_bank
  import irq_merge_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int VIRT_PER_CORE = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [NUM_CORES*VIRT_PER_CORE-1:0] vpend,
  output logic [NUM_CORES-1:0]          vnmi_pulse
);
  localparam int VW = NUM_CORES * VIRT_PER_CORE;

  logic set_wr, clr_wr, nmi_wr;
  logic [DATA_W-1:0] next_pend;

  assign set_wr = wr_en && (reg_addr == A_VSET);
  assign clr_wr = wr_en && (reg_addr == A_VCLR);
  assign nmi_wr = wr_en && (reg_addr == A_VNMI);

  always_comb begin
    next_pend = DATA_W'(vpend);
    if (set_wr || clr_wr)
      next_pend = apply_w1(DATA_W'(vpend), wr_data, set_wr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpend      <= '0;
      vnmi_pulse <= '0;
    end else begin
      vpend      <= next_pend[VW-1:0];
      vnmi_pulse <= nmi_wr ? wr_data[NUM_CORES-1:0] : '0;
    end
  end

  // R2
  w1s_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((vpend & $past(wr_data[VW-1:0])) == $past(wr_data[VW-1:0])));
  // R3
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((vpend & $past(wr_data[VW-1:0])) == '0));
  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_wr || clr_wr) |=> $stable(vpend));
  // R6
  vnmi_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vnmi_pulse != '0) |-> $past(nmi_wr));
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_merge_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_HW    = 16,
  parameter int NUM_NMI   = 4,
  parameter int VIRT_PER_CORE = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_HW-1:0]             hw_q,
  input  logic [NUM_NMI-1:0]            nmi_q,
  input  logic [NUM_CORES*VIRT_PER_CORE-1:0] vpend,
  input  logic [NUM_CORES*VIRT_PER_CORE-1:0] vmask,
  input  logic [NUM_CORES*NUM_HW-1:0]   core_en,
  input  logic [NUM_HW-1:0]             ext_en,
  input  logic [NUM_CORES-1:0]          vnmi_pulse,
  output logic [NUM_CORES-1:0]          core_int,
  output logic [NUM_CORES-1:0]          core_nmi,
  output logic                          int_out,
  output logic                          nmi_out
);
  logic hw_nmi_any;
  logic [NUM_CORES-1:0] hw_hit, virt_hit;

  assign hw_nmi_any = |nmi_q;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign hw_hit[c]   = any_hit(DATA_W'(hw_q), DATA_W'(core_en[c*NUM_HW +: NUM_HW]));
    assign virt_hit[c] = any_hit(DATA_W'(vpend[c*VIRT_PER_CORE +: VIRT_PER_CORE]),
                                 DATA_W'(vmask[c*VIRT_PER_CORE +: VIRT_PER_CORE]));
    assign core_int[c] = hw_hit[c] | virt_hit[c];
    assign core_nmi[c] = vnmi_pulse[c] | hw_nmi_any;
  end

  assign int_out = any_hit(DATA_W'(hw_q), DATA_W'(ext_en));
  assign nmi_out = hw_nmi_any;

  // R4
  quiet_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hw_q == '0) && ((vpend & vmask) == '0)) |-> (core_int == '0));
  // R5
  ext_int_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((hw_q & ext_en) != '0));
  // R7
  nmi_fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_out |-> (&core_nmi));
endmodule

// File: rtl/irq_merge_hub.sv
module irq_merge_hub
  import irq_merge_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_HW    = 16,
  parameter int NUM_NMI   = 4,
  parameter int VIRT_PER_CORE = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_HW-1:0]      hw_irq,
  input  logic [NUM_NMI-1:0]     hw_nmi,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [DATA_W-1:0]      rd_data,
  output logic [NUM_CORES-1:0]   core_int,
  output logic [NUM_CORES-1:0]   core_nmi,
  output logic                   int_out,
  output logic                   nmi_out
);
  localparam int VW = NUM_CORES * VIRT_PER_CORE;

  logic [NUM_HW-1:0]           hw_q;
  logic [NUM_NMI-1:0]          nmi_q;
  logic [VW-1:0]               vpend, vmask;
  logic [NUM_CORES*NUM_HW-1:0] core_en;
  logic [NUM_HW-1:0]           ext_en;
  logic [NUM_CORES-1:0]        vnmi_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hw_q  <= '0;
      nmi_q <= '0;
    end else begin
      hw_q  <= hw_irq;
      nmi_q <= hw_nmi;
    end
  end

  irq_cfg_regs #(.NUM_CORES(NUM_CORES), .NUM_HW(NUM_HW), .VIRT_PER_CORE(VIRT_PER_CORE))
  u_cfg (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data),
         .vmask(vmask), .core_en(core_en), .ext_en(ext_en));

  irq_virt_bank #(.NUM_CORES(NUM_CORES), .VIRT_PER_CORE(VIRT_PER_CORE))
  u_virt (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data),
          .vpend(vpend), .vnmi_pulse(vnmi_pulse));

  irq_route #(.NUM_CORES(NUM_CORES), .NUM_HW(NUM_HW), .NUM_NMI(NUM_NMI),
              .VIRT_PER_CORE(VIRT_PER_CORE))
  u_route (.clk(clk), .rst_n(rst_n), .hw_q(hw_q), .nmi_q(nmi_q), .vpend(vpend),
           .vmask(vmask), .core_en(core_en), .ext_en(ext_en), .vnmi_pulse(vnmi_pulse),
           .core_int(core_int), .core_nmi(core_nmi), .int_out(int_out), .nmi_out(nmi_out));

  always_comb begin
    rd_data = '0;
    case (reg_addr)
      A_VSET, A_VCLR: rd_data = DATA_W'(vpend);
      A_VMASK:        rd_data = DATA_W'(vmask);
      A_EXTEN:        rd_data = DATA_W'(ext_en);
      A_HWSTAT:       rd_data = DATA_W'(hw_q);
      A_NMISTAT:      rd_data = DATA_W'(nmi_q);
      default: begin
        for (int c = 0; c < NUM_CORES; c++)
          if (reg_addr == cen_addr(c)) rd_data = DATA_W'(core_en[c*NUM_HW +: NUM_HW]);
      end
    endcase
  end

  // R9
  hw_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_HWSTAT) |-> (rd_data == DATA_W'(hw_q)));
endmodule

// File: tb/irq_merge_hub_tb_top.sv
module irq_merge_hub_tb_top;
  logic clk = 0, rst_n = 0;
  logic [15:0] hw_irq = '0;
  logic [3:0]  hw_nmi = '0;
  logic        wr_en = 0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  core_int, core_nmi;
  logic        int_out, nmi_out;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_merge_hub dut_i (.clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .hw_nmi(hw_nmi),
    .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
    .core_int(core_int), .core_nmi(core_nmi), .int_out(int_out), .nmi_out(nmi_out));

  // Configuration used by the vector walk
  localparam logic [31:0] CFG_VMASK = 32'h00FF_00F0;
  localparam logic [15:0] CFG_EXT   = 16'h8001;

  // Stimulus vectors: {hw_irq[15:0], virtual set word[31:0]}
  localparam int NV = 8;
  localparam logic [47:0] VEC [NV] = '{
    {16'h0000, 32'h0000_0000}, {16'h0001, 32'h0000_0000},
    {16'h0000, 32'h0000_000F}, {16'h0000, 32'h0000_0010},
    {16'h0020, 32'hFF00_0000}, {16'h8000, 32'h0001_0000},
    {16'h0F00, 32'h0100_0100}, {16'hFFFF, 32'hFFFF_FFFF}};

  function automatic logic [15:0] cen_of(input int c);
    return 16'h000F << (4 * c);
  endfunction

  function automatic logic [3:0] model_int(input logic [15:0] h, input logic [31:0] v);
    logic [3:0] r;
    for (int c = 0; c < 4; c++)
      r[c] = ((h & cen_of(c)) != 0) || (((v & CFG_VMASK) >> (8 * c)) & 32'hFF) != 0;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; reg_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 outputs", {22'd0, core_int, core_nmi, int_out, nmi_out}, 32'd0);
    for (int a = 0; a < 11; a++) rd_chk("R1 regs", 4'(a), 32'd0);

    // configure
    wr(4'd3, CFG_VMASK);
    wr(4'd8, {16'd0, CFG_EXT});
    for (int c = 0; c < 4; c++) wr(4'(4 + c), {16'd0, cen_of(c)});
    // R9 readback
    rd_chk("R9 vmask readback", 4'd3, CFG_VMASK);
    rd_chk("R9 ext readback", 4'd8, {16'd0, CFG_EXT});
    rd_chk("R9 core2 en readback", 4'd6, 32'h0000_0F00);

    // vector walk, R4 R5
    for (int i = 0; i < NV; i++) begin
      wr(4'd1, 32'hFFFF_FFFF);
      wr(4'd0, VEC[i][31:0]);
      hw_irq = VEC[i][47:32];
      @(negedge clk);
      chk("R4 core_int", {28'd0, core_int}, {28'd0, model_int(VEC[i][47:32], VEC[i][31:0])});
      chk("R5 int_out", {31'd0, int_out}, {31'd0, (VEC[i][47:32] & CFG_EXT) != 0});
      rd_chk("R9 hw status", 4'd9, {16'd0, VEC[i][47:32]});
      rd_chk("R2 pending", 4'd0, VEC[i][31:0]);
    end
    hw_irq = '0;

    // R2 W1S keeps other bits
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd0, 32'h0000_0300);
    wr(4'd0, 32'h0400_0001);
    rd_chk("R2 w1s merge", 4'd0, 32'h0400_0301);
    // R3 W1C clears only written bits
    wr(4'd1, 32'h0000_0101);
    rd_chk("R3 w1c partial", 4'd1, 32'h0400_0200);
    // R8 mask changes leave pending; core1 byte masked (vmask byte1 = 00)
    chk("R8 masked core1", {31'd0, core_int[1]}, 32'd0);
    wr(4'd3, 32'h0000_FF00);
    chk("R8 unmasked core1", {28'd0, core_int}, 32'h2);
    wr(4'd3, 32'h0);
    rd_chk("R8 pending kept", 4'd0, 32'h0400_0200);
    chk("R8 remasked", {28'd0, core_int}, 32'h0);

    // R9 writes to status ignored
    hw_irq = 16'h00A5;
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd10, 32'hF);
    rd_chk("R9 hw stat ro", 4'd9, 32'h00A5);
    rd_chk("R9 nmi stat ro", 4'd10, 32'h0);
    hw_irq = '0;

    // R6 virtual NMI pulse, masks all zero
    wr(4'd2, 32'h0000_0005);
    chk("R6 pulse high", {28'd0, core_nmi}, 32'h5);
    chk("R6 no nmi_out", {31'd0, nmi_out}, 32'd0);
    @(negedge clk);
    chk("R6 pulse one cycle", {28'd0, core_nmi}, 32'h0);
    rd_chk("R6 trigger reads 0", 4'd2, 32'h0);

    // R7 hardware NMI
    hw_nmi = 4'b0100;
    @(negedge clk);
    chk("R7 nmi fanout", {27'd0, nmi_out, core_nmi}, {27'd0, 1'b1, 4'hF});
    rd_chk("R7 nmi status", 4'd10, 32'h4);
    hw_nmi = '0;
    @(negedge clk);
    chk("R7 nmi drop", {27'd0, nmi_out, core_nmi}, 32'd0);

    // R1 reset after activity
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd3, 32'hFFFF_FFFF);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd_chk("R1 pend after reset", 4'd0, 32'd0);
    rd_chk("R1 vmask after reset", 4'd3, 32'd0);
    chk("R1 core_int after reset", {28'd0, core_int}, 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule